// File: doc/BRIEF.md
# Age-Constrained Register Prefetch Scheduler

This block sits inside a core's bus wrapper. It keeps a local copy of each internal core register, so a read from the system bus is answered in the same cycle from that copy and never waits for the core. The block owns a narrow internal bus to the core. Over that bus it refreshes each copy often enough that no copy grows older than the age limit set for its register.

Every register has a compile-time age limit. A register becomes due for refresh once its copy has aged to within a fixed lead of that limit. Among the due registers, the one with the smallest limit is refreshed first. This is a fixed, rate-monotonic priority, and a tie goes to the lower index. A write from the system bus is treated as one more schedulable entry whose deadline is immediate. It takes the next free internal-bus slot ahead of every due refresh, and the refreshes behind it are delayed. Each internal-bus transaction lasts two cycles and is never interrupted. An overrun flag shows any cycle in which some copy is older than its limit.

Top module: `pf_prefetch_sched`

## Requirements
- R1: After reset `core_req_o` and `overrun_o` are 0, and every copy reads 0.
- R2: `rd_data_o` shows the copy selected by `rd_addr_i` in the same cycle, combinationally, and never waits for the internal bus.
- R3: An internal-bus transaction holds `core_req_o`=1 for exactly two cycles, with `core_addr_o`, `core_we_o` and `core_wdata_o` stable across both. For a read (`core_we_o`=0), `core_rdata_i` is sampled at the end of the second cycle, and the new copy is visible from the next cycle.
- R4: A register's age is the number of cycles since its copy was last loaded. It is 0 after reset and after a load, and it saturates at its maximum. The register is due once its age is at least its limit minus `REFRESH_LEAD`, and it stays due until it is refreshed.
- R5: When a refresh starts, it goes to the due register with the smallest age limit, and a tie goes to the lower index. A register whose refresh ends in the deciding cycle is not a candidate.
- R6: A system-bus write (`wr_req_i`=1 for one cycle) runs as an internal-bus transaction with `core_we_o`=1. It starts in the next free slot, ahead of any due refresh. If it arrives during the first cycle of a transaction, it waits exactly one extra cycle.
- R7: A started transaction always completes. When work is pending, the next transaction follows the last with no idle cycle, and the bus idles only when nothing is due and no write is waiting.
- R8: `overrun_o` is 1 in exactly those cycles in which some register's age exceeds its age limit.
- R9: A write request that arrives while an earlier write is still waiting is dropped. A write never changes a local copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_addr_i | input | IW | Register index read by the system bus |
| rd_data_o | output | DATA_W | Local copy of the selected register |
| wr_req_i | input | 1 | System-bus write request, one cycle per write |
| wr_addr_i | input | IW | Register index written |
| wr_data_i | input | DATA_W | Write data |
| core_req_o | output | 1 | Internal-bus transaction active |
| core_we_o | output | 1 | 1 for a write, 0 for a refresh read |
| core_addr_o | output | IW | Register index on the internal bus |
| core_wdata_o | output | DATA_W | Write data toward the core |
| core_rdata_i | input | DATA_W | Core register value, sampled in a read's second cycle |
| overrun_o | output | 1 | Some copy is older than its age limit |

## Verification
Two functions can fall in the same cycle. A write can arrive while a refresh is in its first cycle, and a refresh can be due in the very slot where a queued write gets the bus. The bench provokes the first case by issuing a write in the cycle the first refresh starts, with a second write close behind. It then expects the write to appear two cycles later and the second write never to appear. Under random sparse writes and a sustained write burst, a behavioural model of the age counters and the priority order predicts, on every clock, the owner of the internal bus, every copy and the overrun flag.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic {
    PH_ADDR = 1'b0,
    PH_DATA = 1'b1
  } bus_phase_e;
endpackage

// File: rtl/pf_age_slot.sv
module pf_age_slot #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned AGE_W  = 8,
  parameter int unsigned LIMIT  = 32,
  parameter int unsigned LEAD   = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [DATA_W-1:0] upd_data_i,
  output logic [DATA_W-1:0] copy_o,
  output logic              due_o,
  output logic              over_o
);
  localparam logic [AGE_W-1:0] DueAt  = AGE_W'(LIMIT - LEAD);
  localparam logic [AGE_W-1:0] LimAge = AGE_W'(LIMIT);

  logic [AGE_W-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q  <= '0;
      copy_o <= '0;
    end else if (upd_i) begin
      age_q  <= '0;
      copy_o <= upd_data_i;
    end else if (age_q != '1) begin
      age_q <= age_q + 1'b1;
    end
  end

  assign due_o  = (age_q >= DueAt);
  assign over_o = (age_q > LimAge);

  a_r4_age_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (age_q == '0));
  a_r4_due_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (due_o && !upd_i) |=> due_o);
endmodule

// File: rtl/pf_rm_arbiter.sv
module pf_rm_arbiter #(
  parameter int unsigned        N_REGS = 4,
  parameter int unsigned        AGE_W  = 8,
  parameter logic [N_REGS*AGE_W-1:0] LIMITS = '0,
  localparam int unsigned       IW     = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
  input  logic [N_REGS-1:0] req_i,
  output logic              valid_o,
  output logic [IW-1:0]     idx_o
);
  function automatic logic [AGE_W-1:0] lim_at(input int i);
    return LIMITS[i*AGE_W +: AGE_W];
  endfunction

  logic [AGE_W-1:0] best;

  // smallest age limit wins; strict compare keeps the lower index on a tie
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    best    = '1;
    for (int i = 0; i < int'(N_REGS); i++) begin
      if (req_i[i] && (!valid_o || lim_at(i) < best)) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
        best    = lim_at(i);
      end
    end
  end

  always_comb begin
    if (valid_o) begin
      a_r5_grant_is_due: assert (req_i[idx_o]);
      for (int j = 0; j < int'(N_REGS); j++) begin
        if (req_i[j]) begin
          a_r5_rate_monotonic: assert (lim_at(j) > lim_at(int'(idx_o)) ||
            (lim_at(j) == lim_at(int'(idx_o)) && j >= int'(idx_o)));
        end
      end
    end
  end
endmodule

// File: rtl/pf_bus_seq.sv
module pf_bus_seq
  import pf_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IW     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_req_i,
  input  logic [IW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_valid_i,
  input  logic [IW-1:0]     rd_idx_i,
  output logic              core_req_o,
  output logic              core_we_o,
  output logic [IW-1:0]     core_addr_o,
  output logic [DATA_W-1:0] core_wdata_o,
  output logic              upd_o
);
  bus_phase_e        phase_q;
  logic              busy_q, pend_q;
  logic [IW-1:0]     pend_addr_q;
  logic [DATA_W-1:0] pend_data_q;
  logic              free;

  assign free = !busy_q || (phase_q == PH_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q       <= 1'b0;
      phase_q      <= PH_ADDR;
      core_we_o    <= 1'b0;
      core_addr_o  <= '0;
      core_wdata_o <= '0;
      pend_q       <= 1'b0;
      pend_addr_q  <= '0;
      pend_data_q  <= '0;
    end else if (free) begin
      phase_q <= PH_ADDR;
      if (pend_q) begin
        busy_q       <= 1'b1;
        core_we_o    <= 1'b1;
        core_addr_o  <= pend_addr_q;
        core_wdata_o <= pend_data_q;
        pend_q       <= 1'b0;
      end else if (wr_req_i) begin
        busy_q       <= 1'b1;
        core_we_o    <= 1'b1;
        core_addr_o  <= wr_addr_i;
        core_wdata_o <= wr_data_i;
      end else if (rd_valid_i) begin
        busy_q      <= 1'b1;
        core_we_o   <= 1'b0;
        core_addr_o <= rd_idx_i;
      end else begin
        busy_q <= 1'b0;
      end
    end else begin
      phase_q <= PH_DATA;
      if (wr_req_i && !pend_q) begin
        pend_q      <= 1'b1;
        pend_addr_q <= wr_addr_i;
        pend_data_q <= wr_data_i;
      end
    end
  end

  assign core_req_o = busy_q;
  assign upd_o      = busy_q && (phase_q == PH_DATA) && !core_we_o;

  a_r3_hold_two_cycles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_req_o && phase_q == PH_ADDR) |=>
      (core_req_o && $stable(core_addr_o) && $stable(core_we_o) && $stable(core_wdata_o)));
  a_r6_wait_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |=> !pend_q);
  a_r6_write_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free && pend_q) |=> (core_req_o && core_we_o));
  a_r7_no_idle_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free && (rd_valid_i || wr_req_i)) |=> core_req_o);
endmodule

// File: rtl/pf_prefetch_sched.sv
module pf_prefetch_sched #(
  parameter int unsigned N_REGS       = 4,
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned AGE_W        = 8,
  parameter int unsigned REFRESH_LEAD = 12,
  // per-register age limit, register 0 in the low field
  parameter logic [N_REGS*AGE_W-1:0] AGE_LIMITS = 32'h2040_1828,
  localparam int unsigned IW = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_req_i,
  input  logic [IW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              core_req_o,
  output logic              core_we_o,
  output logic [IW-1:0]     core_addr_o,
  output logic [DATA_W-1:0] core_wdata_o,
  input  logic [DATA_W-1:0] core_rdata_i,
  output logic              overrun_o
);
  logic [N_REGS-1:0] due, over, upd_hit;
  logic [DATA_W-1:0] copy_w [N_REGS];
  logic              seq_upd, arb_valid;
  logic [IW-1:0]     arb_idx;

  for (genvar g = 0; g < int'(N_REGS); g++) begin : g_slot
    assign upd_hit[g] = seq_upd && (core_addr_o == IW'(g));
    pf_age_slot #(
      .DATA_W(DATA_W),
      .AGE_W (AGE_W),
      .LIMIT (int'(AGE_LIMITS[g*AGE_W +: AGE_W])),
      .LEAD  (REFRESH_LEAD)
    ) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .upd_i     (upd_hit[g]),
      .upd_data_i(core_rdata_i),
      .copy_o    (copy_w[g]),
      .due_o     (due[g]),
      .over_o    (over[g])
    );
  end

  pf_rm_arbiter #(
    .N_REGS(N_REGS),
    .AGE_W (AGE_W),
    .LIMITS(AGE_LIMITS)
  ) u_arb (
    .req_i  (due & ~upd_hit),
    .valid_o(arb_valid),
    .idx_o  (arb_idx)
  );

  pf_bus_seq #(
    .DATA_W(DATA_W),
    .IW    (IW)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_req_i    (wr_req_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .rd_valid_i  (arb_valid),
    .rd_idx_i    (arb_idx),
    .core_req_o  (core_req_o),
    .core_we_o   (core_we_o),
    .core_addr_o (core_addr_o),
    .core_wdata_o(core_wdata_o),
    .upd_o       (seq_upd)
  );

  assign rd_data_o = (int'(rd_addr_i) < int'(N_REGS)) ? copy_w[rd_addr_i] : '0;
  assign overrun_o = |over;

  a_r1_reset_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!core_req_o && !overrun_o));
  a_r9_write_keeps_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_req_o && core_we_o) |=> (rd_addr_i != $past(core_addr_o)) ||
      $stable(rd_addr_i) == 1'b0 || $stable(rd_data_o));
endmodule

// File: tb/tb_pf_prefetch_sched.sv
module tb_pf_prefetch_sched;
  localparam int N = 4, DW = 16, LEAD = 12;
  localparam int LIM [N] = '{40, 24, 64, 32};

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]    rd_addr = '0, wr_addr = '0, core_addr;
  logic [DW-1:0] rd_data, wr_data = '0, core_wdata, core_rdata;
  logic          wr_req = 1'b0, core_req, core_we, overrun;
  logic [DW-1:0] core_mem [N];

  assign core_rdata = core_mem[core_addr];

  pf_prefetch_sched dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .wr_req_i(wr_req), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .core_req_o(core_req), .core_we_o(core_we), .core_addr_o(core_addr),
    .core_wdata_o(core_wdata), .core_rdata_i(core_rdata), .overrun_o(overrun));

  int checks = 0, errors = 0;
  bit done = 0, seen_over = 0;

  // behavioural reference
  int            m_age [N];
  logic [DW-1:0] m_copy [N];
  bit            m_busy, m_ph, m_we, m_pend;
  int            m_addr, m_paddr;
  logic [DW-1:0] m_wdata, m_pdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_age[i] = 0; m_copy[i] = '0; end
      m_busy = 0; m_ph = 0; m_we = 0; m_pend = 0; m_addr = 0; m_paddr = 0;
      m_wdata = '0; m_pdata = '0;
    end else begin
      automatic bit free = !m_busy || m_ph;
      automatic int pick = -1;
      automatic int nage [N];
      for (int i = 0; i < N; i++) begin
        automatic bit loading = m_busy && m_ph && !m_we && m_addr == i;
        automatic bit due = (m_age[i] >= LIM[i] - LEAD) && !loading;
        if (due && (pick < 0 || LIM[i] < LIM[pick])) pick = i;
        if (loading) begin m_copy[i] = core_mem[i]; nage[i] = 0; end
        else nage[i] = (m_age[i] < 255) ? m_age[i] + 1 : 255;
      end
      if (free) begin
        m_ph = 0;
        if (m_pend) begin
          m_busy = 1; m_we = 1; m_addr = m_paddr; m_wdata = m_pdata; m_pend = 0;
        end else if (wr_req) begin
          m_busy = 1; m_we = 1; m_addr = wr_addr; m_wdata = wr_data;
        end else if (pick >= 0) begin
          m_busy = 1; m_we = 0; m_addr = pick;
        end else m_busy = 0;
      end else begin
        m_ph = 1;
        if (wr_req && !m_pend) begin m_pend = 1; m_paddr = wr_addr; m_pdata = wr_data; end
      end
      for (int i = 0; i < N; i++) m_age[i] = nage[i];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    automatic bit m_over = 0;
    for (int i = 0; i < N; i++) if (m_age[i] > LIM[i]) m_over = 1;
    chk(core_req == m_busy, "R7 core_req_o", core_req, m_busy);
    if (m_busy) begin
      chk(core_addr == m_addr[1:0], "R5 core_addr_o", core_addr, m_addr);
      chk(core_we == m_we, "R6 core_we_o", core_we, m_we);
      if (m_we) chk(core_wdata == m_wdata, "R6 core_wdata_o", core_wdata, m_wdata);
    end
    chk(rd_data == m_copy[rd_addr], "R2 R3 rd_data_o", rd_data, m_copy[rd_addr]);
    chk(overrun == m_over, "R8 overrun_o", overrun, m_over);
    if (overrun) seen_over = 1;
  endtask

  // one clock: edge, then compare at the falling edge and let the core absorb writes
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
    if (core_req && core_we) core_mem[core_addr] = core_wdata;
  endtask

  logic [31:0] lfsr = 32'h1234_5677;
  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    automatic int k = 0;
    automatic int gap = 0;
    for (int i = 0; i < N; i++) core_mem[i] = DW'(16'h1000 + i * 16'h1111);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(core_req == 0, "R1 core_req_o", core_req, 0);
    chk(overrun == 0, "R1 overrun_o", overrun, 0);
    for (int i = 0; i < N; i++) begin
      rd_addr = 2'(i); #1;
      chk(rd_data == 0, "R1 copy", rd_data, 0);
    end
    rd_addr = 2'd1;
    rst_n = 1'b1;

    // R4/R5: register 1 has the smallest limit 24, due at age 12 -> starts after edge 13
    do begin k++; tick(); end while (!core_req && k < 40);
    chk(k == 13, "R4 first refresh cycle", k, 13);
    chk(core_addr == 2'd1 && !core_we, "R5 first refresh index", core_addr, 1);

    // R6/R9: write lands during the first cycle of that refresh, a second one follows while queued
    wr_req = 1; wr_addr = 2'd2; wr_data = 16'hABCD;
    tick();
    wr_addr = 2'd3; wr_data = 16'h5555;
    tick();
    wr_req = 0;
    chk(core_req && core_we, "R6 write after one wait cycle", {core_req, core_we}, 2'b11);
    chk(core_addr == 2'd2 && core_wdata == 16'hABCD, "R6 write fields", core_wdata, 16'hABCD);
    tick();
    tick();
    chk(core_req == 0, "R9 queued duplicate write dropped", core_req, 0);
    rd_addr = 2'd2; #1;
    chk(rd_data == 0, "R9 write leaves copy unchanged", rd_data, 0);
    rd_addr = 2'd1; #1;
    chk(rd_data == 16'h2111, "R3 copy loaded by refresh", rd_data, 16'h2111);

    // sparse random writes with a changing core
    seen_over = 0;
    for (int c = 0; c < 2000; c++) begin
      lfsr = nxt(lfsr);
      core_mem[lfsr[9:8]] = lfsr[31:16];
      rd_addr = lfsr[3:2];
      gap++;
      wr_req = (gap >= 16) && lfsr[4];
      if (wr_req) begin gap = 0; wr_addr = lfsr[6:5]; wr_data = lfsr[27:12]; end
      tick();
    end
    wr_req = 0;
    chk(seen_over == 0, "R8 no overrun under sparse writes", seen_over, 0);

    // sustained write burst starves refreshes
    for (int c = 0; c < 80; c++) begin
      lfsr = nxt(lfsr);
      wr_req = 1; wr_addr = lfsr[1:0]; wr_data = lfsr[23:8];
      rd_addr = lfsr[5:4];
      tick();
    end
    wr_req = 0;
    chk(seen_over == 1, "R8 overrun raised when starved", seen_over, 1);
    k = 0;
    for (int c = 0; c < 8; c++) begin tick(); if (core_req) k++; end
    chk(k == 8, "R7 back-to-back after burst", k, 8);
    for (int c = 0; c < 200; c++) begin
      lfsr = nxt(lfsr);
      rd_addr = lfsr[1:0];
      tick();
    end
    chk(overrun == 0, "R8 overrun clears after recovery", overrun, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule